// File: doc/BRIEF.md
# 16-bit ModRM Address Generator

This block works out the effective offset of a memory operand under 16-bit addressing. A ModRM byte and up to two displacement bytes arrive one byte per cycle on a valid/ready byte stream. The block also receives the current BX, BP, SI and DI register values and a segment override code. The ModRM byte alone tells the block how many displacement bytes follow. Once the last byte of the operand is accepted, the block produces one registered result. That result holds the 16-bit offset, the segment that applies, the number of stream bytes consumed, and a flag for an encoding that cannot name memory.

The offset is the sum of a fixed base/index register pair chosen by rm and the displacement chosen by mod, wrapped to 16 bits. Forms built on BP move the default segment to the stack segment. The one exception is the direct form (mod 0, rm 6), which replaces BP with a bare 16-bit displacement. Segment translation and instruction fetch are left to neighbouring blocks.

Top module: `modrm16_agen`

## Requirements
- R1: The rm field (ModRM bits 2:0) selects the register sum: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX.
- R2: With mod (ModRM bits 7:6) equal to 0 and rm other than 6, no displacement byte is consumed and the offset is the register sum alone.
- R3: With mod 1, one displacement byte is consumed, sign-extended, and added to the register sum.
- R4: With mod 2, two displacement bytes are consumed, low byte first, and added to the register sum.
- R5: With mod 0 and rm 6, two displacement bytes (low first) form the offset directly, with no register added and no switch to the stack segment.
- R6: With no override, rm 2, 3 or 6 (excluding the direct form) yields segment SS; all other valid forms yield DS.
- R7: Segment codes are 0 none, 1 ES, 2 CS, 3 SS, 4 DS, 5 FS, 6 GS. An override other than none, sampled with the ModRM byte, is passed to out_seg unchanged.
- R8: mod 3 consumes only the ModRM byte and raises out_invalid, with out_offset 0 and out_seg 0.
- R9: The offset is wrapped to 16 bits: register sum plus displacement modulo 65536.
- R10: out_valid is high for the cycle after the last operand byte is accepted. out_len then gives the bytes consumed (1 to 3). Register values are taken in the cycle of that last byte.
- R11: While rst is high, in_ready and out_valid are low. One cycle after rst falls, in_ready is high.
- R12: out_invalid is low whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Block accepts a byte |
| in_byte | input | 8 | ModRM byte, then displacement bytes |
| seg_ovr | input | 3 | Segment override code, sampled with ModRM |
| reg_bx | input | W | BX value |
| reg_bp | input | W | BP value |
| reg_si | input | W | SI value |
| reg_di | input | W | DI value |
| out_valid | output | 1 | Result present for one cycle |
| out_offset | output | W | Effective offset |
| out_seg | output | 3 | Effective segment code |
| out_len | output | 2 | Stream bytes consumed |
| out_invalid | output | 1 | mod 3 used for a memory operand |

## Verification
The assertions check these on every cycle: the reset behaviour of the handshake, the tie between out_invalid and out_valid, the fixed shape of an invalid result (one byte, zero offset, no segment), and that a valid result always carries a real segment and a byte count in range. Only the bench's scenarios can show the arithmetic. That covers the pair table, the sign extension of a short displacement, the byte order of a long one, the wrap at 16 bits, and the choice between SS, DS and an override. To do so, the bench sweeps all 256 ModRM values under several register and displacement patterns and rotates through every override code.

// File: rtl/modrm16_pkg.sv
package modrm16_pkg;

  typedef enum logic [2:0] {
    SEG_NONE = 3'd0,
    SEG_ES   = 3'd1,
    SEG_CS   = 3'd2,
    SEG_SS   = 3'd3,
    SEG_DS   = 3'd4,
    SEG_FS   = 3'd5,
    SEG_GS   = 3'd6
  } seg_e;

  typedef enum logic [1:0] {
    ST_MODRM = 2'd0,
    ST_DLO   = 2'd1,
    ST_DHI   = 2'd2
  } cst_e;

  // Number of displacement bytes that follow a given ModRM byte.
  function automatic logic [1:0] disp_bytes(input logic [7:0] m);
    logic [1:0] md;
    logic [2:0] rm;
    md = m[7:6];
    rm = m[2:0];
    case (md)
      2'd0:    disp_bytes = (rm == 3'd6) ? 2'd2 : 2'd0;
      2'd1:    disp_bytes = 2'd1;
      2'd2:    disp_bytes = 2'd2;
      default: disp_bytes = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/modrm16_collect.sv
module modrm16_collect
  import modrm16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic [2:0] seg_in,
  output logic       in_ready,
  output logic       done,
  output logic [7:0] modrm_o,
  output logic [7:0] dlo_o,
  output logic [7:0] dhi_o,
  output logic [2:0] seg_o,
  output logic [1:0] len_o
);

  cst_e       st;
  logic       ready_q;
  logic [7:0] modrm_r;
  logic [7:0] dlo_r;
  logic [2:0] seg_r;
  logic       acc;
  logic [1:0] need;

  assign in_ready = ready_q;

  always_comb begin
    acc     = in_valid & ready_q;
    modrm_o = (st == ST_MODRM) ? in_byte : modrm_r;
    seg_o   = (st == ST_MODRM) ? seg_in : seg_r;
    dlo_o   = (st == ST_DLO) ? in_byte : dlo_r;
    dhi_o   = in_byte;
    need    = disp_bytes(modrm_o);
    len_o   = need + 2'd1;
    done    = acc && (((st == ST_MODRM) && (need == 2'd0)) ||
                      ((st == ST_DLO) && (need == 2'd1)) ||
                      (st == ST_DHI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_MODRM;
      ready_q <= 1'b0;
      modrm_r <= '0;
      dlo_r   <= '0;
      seg_r   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (acc) begin
        case (st)
          ST_MODRM: begin
            modrm_r <= in_byte;
            seg_r   <= seg_in;
            if (need != 2'd0) st <= ST_DLO;
          end
          ST_DLO: begin
            dlo_r <= in_byte;
            st    <= (need == 2'd2) ? ST_DHI : ST_MODRM;
          end
          default: st <= ST_MODRM;
        endcase
      end
    end
  end

endmodule

// File: rtl/modrm16_sum.sv
module modrm16_sum
  import modrm16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [7:0]   modrm,
  input  logic [7:0]   dlo,
  input  logic [7:0]   dhi,
  input  logic [2:0]   seg_ovr,
  input  logic [W-1:0] bx,
  input  logic [W-1:0] bp,
  input  logic [W-1:0] si,
  input  logic [W-1:0] di,
  output logic [W-1:0] offset,
  output logic [2:0]   seg,
  output logic         invalid
);

  logic [1:0]   md;
  logic [2:0]   rm;
  logic         direct;
  logic         bp_form;
  logic [W-1:0] regsum;
  logic [W-1:0] disp;

  always_comb begin
    md     = modrm[7:6];
    rm     = modrm[2:0];
    direct = (md == 2'd0) && (rm == 3'd6);

    case (rm)
      3'd0:    regsum = bx + si;
      3'd1:    regsum = bx + di;
      3'd2:    regsum = bp + si;
      3'd3:    regsum = bp + di;
      3'd4:    regsum = si;
      3'd5:    regsum = di;
      3'd6:    regsum = bp;
      default: regsum = bx;
    endcase

    if (md == 2'd1)
      disp = W'($signed(dlo));
    else if ((md == 2'd2) || direct)
      disp = W'({dhi, dlo});
    else
      disp = '0;

    bp_form = ((rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6)) && !direct;
    invalid = (md == 2'd3);

    if (invalid) begin
      offset = '0;
      seg    = SEG_NONE;
    end else begin
      offset = direct ? disp : (regsum + disp);
      if (seg_ovr != SEG_NONE) seg = seg_ovr;
      else if (bp_form)        seg = SEG_SS;
      else                     seg = SEG_DS;
    end
  end

endmodule

// File: rtl/modrm16_agen.sv
module modrm16_agen
  import modrm16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [7:0]   in_byte,
  input  logic [2:0]   seg_ovr,
  input  logic [W-1:0] reg_bx,
  input  logic [W-1:0] reg_bp,
  input  logic [W-1:0] reg_si,
  input  logic [W-1:0] reg_di,
  output logic         out_valid,
  output logic [W-1:0] out_offset,
  output logic [2:0]   out_seg,
  output logic [1:0]   out_len,
  output logic         out_invalid
);

  logic         done;
  logic [7:0]   c_modrm;
  logic [7:0]   c_dlo;
  logic [7:0]   c_dhi;
  logic [2:0]   c_seg;
  logic [1:0]   c_len;
  logic [W-1:0] s_offset;
  logic [2:0]   s_seg;
  logic         s_invalid;

  modrm16_collect i_collect (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .seg_in   (seg_ovr),
    .in_ready (in_ready),
    .done     (done),
    .modrm_o  (c_modrm),
    .dlo_o    (c_dlo),
    .dhi_o    (c_dhi),
    .seg_o    (c_seg),
    .len_o    (c_len)
  );

  modrm16_sum #(.W(W)) i_sum (
    .modrm   (c_modrm),
    .dlo     (c_dlo),
    .dhi     (c_dhi),
    .seg_ovr (c_seg),
    .bx      (reg_bx),
    .bp      (reg_bp),
    .si      (reg_si),
    .di      (reg_di),
    .offset  (s_offset),
    .seg     (s_seg),
    .invalid (s_invalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_offset  <= '0;
      out_seg     <= '0;
      out_len     <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= done;
      if (done) begin
        out_offset  <= s_offset;
        out_seg     <= s_seg;
        out_len     <= c_len;
        out_invalid <= s_invalid;
      end else begin
        out_invalid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/modrm16_agen_chk.sv
module modrm16_agen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [W-1:0] out_offset,
  input logic [2:0]   out_seg,
  input logic [1:0]   out_len,
  input logic         out_invalid
);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready));

  // R11
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);

  // R12
  invalid_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_invalid);

  // R8
  invalid_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (out_len == 2'd1 && out_offset == '0 && out_seg == 3'd0));

  // R7
  seg_code_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_invalid) |-> (out_seg != 3'd0 && out_seg <= 3'd6));

  // R10
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len != 2'd0));

  // R10
  result_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));

endmodule

bind modrm16_agen modrm16_agen_chk #(.W(W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_offset  (out_offset),
  .out_seg     (out_seg),
  .out_len     (out_len),
  .out_invalid (out_invalid)
);

// File: tb/test_modrm16_agen.sv
module test_modrm16_agen;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [7:0]   in_byte;
  logic [2:0]   seg_ovr;
  logic [W-1:0] reg_bx, reg_bp, reg_si, reg_di;
  logic         out_valid;
  logic [W-1:0] out_offset;
  logic [2:0]   out_seg;
  logic [1:0]   out_len;
  logic         out_invalid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  modrm16_agen #(.W(W)) i_modrm16_agen (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_byte (in_byte), .seg_ovr (seg_ovr),
    .reg_bx (reg_bx), .reg_bp (reg_bp), .reg_si (reg_si), .reg_di (reg_di),
    .out_valid (out_valid), .out_offset (out_offset), .out_seg (out_seg),
    .out_len (out_len), .out_invalid (out_invalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Send one operand, then check the result and the idle cycle after it.
  task automatic run(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [2:0] ovr);
    logic [1:0]  md;
    logic [2:0]  rm;
    int          nb;
    logic [15:0] base, disp, eoff;
    logic [2:0]  eseg;
    logic        einv;
    string       tag;
    md = m[7:6];
    rm = m[2:0];
    // Expected count of bytes (R2, R3, R4, R5, R8)
    if (md == 2'd3) nb = 1;
    else if (md == 2'd1) nb = 2;
    else if (md == 2'd2 || rm == 3'd6) nb = 3;
    else nb = 1;
    // Register pair table (R1)
    base = 16'h0;
    if (rm == 3'd0 || rm == 3'd1 || rm == 3'd7) base = base + reg_bx;
    if (rm == 3'd2 || rm == 3'd3 || rm == 3'd6) base = base + reg_bp;
    if (rm == 3'd0 || rm == 3'd2 || rm == 3'd4) base = base + reg_si;
    if (rm == 3'd1 || rm == 3'd3 || rm == 3'd5) base = base + reg_di;
    if (md == 2'd1) disp = lo[7] ? (16'hFF00 | {8'h00, lo}) : {8'h00, lo};
    else if (nb == 3) disp = {hi, lo};
    else disp = 16'h0;
    einv = (md == 2'd3);
    if (einv) begin
      eoff = 16'h0; eseg = 3'd0; tag = "R8";
    end else if (md == 2'd0 && rm == 3'd6) begin
      eoff = disp; tag = "R5";
      eseg = (ovr != 3'd0) ? ovr : 3'd4;
    end else begin
      eoff = base + disp; // wrap (R9)
      tag = (md == 2'd1) ? "R3" : (md == 2'd2) ? "R4" : "R2";
      if (ovr != 3'd0) eseg = ovr;                       // R7
      else if (rm == 3'd2 || rm == 3'd3 || rm == 3'd6) eseg = 3'd3; // R6
      else eseg = 3'd4;
    end
    for (int k = 0; k < nb; k++) begin
      in_valid = 1'b1;
      seg_ovr  = ovr;
      in_byte  = (k == 0) ? m : (k == 1) ? lo : hi;
      @(negedge clk);
      if (k < nb - 1) check("R10 early", {31'd0, out_valid}, 32'd0);
    end
    in_valid = 1'b0;
    seg_ovr  = 3'd0;
    check({tag, " R1 R9 offset"}, {16'd0, out_offset}, {16'd0, eoff});
    check({tag, " R6 R7 seg"}, {29'd0, out_seg}, {29'd0, eseg});
    check("R10 valid/len", {29'd0, out_valid, out_len}, {29'd0, 1'b1, 2'(nb)});
    check("R8 invalid", {31'd0, out_invalid}, {31'd0, einv});
    @(negedge clk);
    check("R12 idle", {30'd0, out_valid, out_invalid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi;
    rst = 1'b1; in_valid = 1'b0; in_byte = 8'h0; seg_ovr = 3'd0;
    reg_bx = '0; reg_bp = '0; reg_si = '0; reg_di = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset", {30'd0, in_ready, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 ready", {31'd0, in_ready}, 32'd1);
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: begin reg_bx = 16'h1234; reg_bp = 16'h0200; reg_si = 16'h0030; reg_di = 16'h0004;
                 lo = 8'h7F; hi = 8'h12; end
        1: begin reg_bx = 16'hFFF0; reg_bp = 16'h8001; reg_si = 16'h7FFF; reg_di = 16'h0010;
                 lo = 8'h80; hi = 8'hFF; end
        2: begin reg_bx = 16'hA5C3; reg_bp = 16'h3C96; reg_si = 16'hE001; reg_di = 16'h5A5A;
                 lo = 8'hC5; hi = 8'h3A; end
        default: begin reg_bx = 16'h0000; reg_bp = 16'hFFFF; reg_si = 16'h0001; reg_di = 16'h8000;
                 lo = 8'h01; hi = 8'h80; end
      endcase
      for (int m = 0; m < 256; m++) begin
        run(8'(m), lo, hi, 3'((m + p) % 7));
      end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule